// File: doc/BRIEF.md
# Single-precision to fixed-point converter

This block turns a 32-bit IEEE-754 single-precision value into a signed or unsigned integer of 16, 32 or 64 bits. A programmable count of fraction bits first scales the operand by a power of two, so the same path yields plain integers (count zero) or fixed-point numbers with binary fraction digits. The block rounds the scaled value in one of four selectable directions. It clamps values that do not fit the chosen width and reports an invalid flag and an inexact flag with each result.

The converter is a two-stage pipeline. The first stage decodes the operand and aligns the significand against the binary point. The second stage rounds, checks the range and saturates. It accepts one operand on every cycle that the valid strobe is high. The result appears on a 64-bit port, widened by sign extension (signed mode) or zero extension (unsigned mode).

Top module: `flt_to_fixed`

## Requirements
- R1: A result is marked by `out_done` exactly two clock cycles after the cycle in which `in_vld` is high, one result per accepted operand, back-to-back accepted operands included; `out_done` stays low otherwise.
- R2: The converted quantity is the operand multiplied by 2 to the power `in_fbits`, for any `in_fbits` from 0 to 127; a scaled value that is already an integer converts exactly with no flag.
- R3: `in_rmode` selects rounding: 00 nearest with ties to the even integer, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero.
- R4: `out_inexact` is set when the rounded integer differs from the scaled value and no invalid condition applies.
- R5: A zero or subnormal operand (exponent field 0) of either sign yields 0 with both flags clear.
- R6: A NaN operand (exponent field all ones, fraction field nonzero) yields 0 with `out_invalid` set.
- R7: In signed mode, a rounded value above 2^(W-1)-1 gives 2^(W-1)-1, and one below -2^(W-1) gives -2^(W-1); both set `out_invalid`. W is the selected width.
- R8: In unsigned mode, a negative nonzero rounded value gives 0 with `out_invalid`. A negative value that rounds to zero gives 0 without invalid. A value above 2^W-1 gives 2^W-1 with `out_invalid`.
- R9: Whenever `out_invalid` is set, `out_inexact` is clear in the same result.
- R10: `in_width` encodes W: 00 is 16, 01 is 32, 10 and 11 are 64. In signed mode `out_val` holds the W-bit result sign-extended to 64 bits. In unsigned mode it holds the result zero-extended.
- R11: An infinite operand saturates toward its own sign as in R7 and R8 (unsigned minus infinity gives 0) and sets `out_invalid`.
- R12: After reset `out_done`, `out_val` and both flags are zero, and both flags are low in every cycle where `out_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Operand and controls are valid this cycle |
| in_op | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1 selects a signed result, 0 unsigned |
| in_width | input | 2 | Result width code (R10) |
| in_fbits | input | FBW (7) | Number of fraction bits, scaling by 2^in_fbits |
| in_rmode | input | 2 | Rounding mode code (R3) |
| out_done | output | 1 | Result valid strobe |
| out_val | output | 64 | Extended fixed-point result |
| out_invalid | output | 1 | Invalid operation flag |
| out_inexact | output | 1 | Inexact result flag |

## Verification
The bench attacks the halfway points, where a design with a wrong tie rule would round 2.5 to 3 or -2.5 the wrong way in the directed modes. It also covers the exact edges of every width, such as -32768 against -32769 and 65535 against 65536. At those edges an off-by-one limit either clamps a legal value or lets an illegal one wrap. Negative operands in unsigned mode separate a value that rounds to zero (no invalid) from one that rounds to -1, where a design that forgot to drop inexact under invalid would raise both flags. Infinities, NaNs, subnormals, the highest scale counts and several hundred random operands with gaps in the valid strobe complete the set. The random operands expose wrong alignment shifts and pipeline slips.

// File: rtl/flt_to_fixed.sv
`timescale 1ns/1ps
module flt_to_fixed #(
  parameter int FBW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [31:0]    in_op,
  input  logic           in_signed,
  input  logic [1:0]     in_width,
  input  logic [FBW-1:0] in_fbits,
  input  logic [1:0]     in_rmode,
  output logic           out_done,
  output logic [63:0]    out_val,
  output logic           out_invalid,
  output logic           out_inexact
);
  localparam int MANW = 23;
  localparam int SIGW = MANW + 1;
  localparam int BIAS = 127;
  localparam int RW   = 66;
  localparam int LMAX = RW - SIGW;
  localparam int RSH  = SIGW + 2;
  localparam int XW   = SIGW + RSH;
  localparam int KW   = FBW + 4;

  wire            sgn    = in_op[31];
  wire [7:0]      ex     = in_op[30:23];
  wire [MANW-1:0] mn     = in_op[MANW-1:0];
  wire            is_zero = (ex == 8'd0);
  wire            is_max  = &ex;
  wire            is_nan  = is_max & (|mn);
  wire            is_inf  = is_max & ~(|mn);
  wire [SIGW-1:0] sig    = {1'b1, mn};

  logic signed [KW-1:0] kk;
  assign kk = $signed({{(KW-8){1'b0}}, ex}) + $signed({{(KW-FBW){1'b0}}, in_fbits})
            - $signed(KW'(BIAS + MANW));

  wire          k_neg = kk[KW-1];
  wire          big   = !k_neg && (kk[KW-2:0] >= (KW-1)'(LMAX));
  wire [KW-1:0] nk    = -kk;
  wire [5:0]    rsh   = (nk > KW'(RSH)) ? 6'(RSH) : nk[5:0];

  wire [XW-1:0] xs    = {sig, {RSH{1'b0}}} >> rsh;
  wire [RW-1:0] lsh_v = {{(RW-SIGW){1'b0}}, sig} << kk[5:0];
  wire [RW-1:0] s1_int = k_neg ? {{(RW-SIGW){1'b0}}, xs[XW-1:RSH]} : lsh_v;
  wire          s1_g   = k_neg & xs[RSH-1];
  wire          s1_st  = k_neg & (|xs[RSH-2:0]);
  wire          finite = ~is_zero & ~is_max;

  logic          p_vld, p_neg, p_nan, p_huge, p_g, p_st, p_signed;
  logic [1:0]    p_w, p_rm;
  logic [RW-1:0] p_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_vld    <= 1'b0;
      p_neg    <= 1'b0;
      p_nan    <= 1'b0;
      p_huge   <= 1'b0;
      p_g      <= 1'b0;
      p_st     <= 1'b0;
      p_signed <= 1'b0;
      p_w      <= 2'd0;
      p_rm     <= 2'd0;
      p_int    <= '0;
    end else begin
      p_vld <= in_vld;
      if (in_vld) begin
        p_neg    <= sgn & ~is_zero;
        p_nan    <= is_nan;
        p_huge   <= is_inf | (finite & big);
        p_int    <= finite ? s1_int : '0;
        p_g      <= finite & s1_g;
        p_st     <= finite & s1_st;
        p_signed <= in_signed;
        p_w      <= in_width;
        p_rm     <= in_rmode;
      end
    end
  end

  logic inc;
  always_comb begin
    case (p_rm)
      2'd0:    inc = p_g & (p_st | p_int[0]);
      2'd1:    inc = ~p_neg & (p_g | p_st);
      2'd2:    inc = p_neg & (p_g | p_st);
      default: inc = 1'b0;
    endcase
  end

  wire [RW-1:0] rmag  = p_int + {{(RW-1){1'b0}}, inc};
  wire [6:0]    wbits = (p_w == 2'd0) ? 7'd16 : (p_w == 2'd1) ? 7'd32 : 7'd64;
  wire [63:0]   pos_lim = (64'd1 << (wbits - 7'd1)) - 64'd1;
  wire [63:0]   ulim    = {64{1'b1}} >> (7'd64 - wbits);
  wire [RW-1:0] neg_lim = {2'b00, pos_lim} + RW'(1);

  wire s_ovf = p_huge | (p_neg ? (rmag > neg_lim) : (rmag > {2'b00, pos_lim}));
  wire u_neg = p_neg & (p_huge | (rmag != '0));
  wire u_ovf = ~p_neg & (p_huge | (rmag > {2'b00, ulim}));
  wire [63:0] twos = p_neg ? -rmag[63:0] : rmag[63:0];

  logic [63:0] res;
  logic        inv;
  always_comb begin
    if (p_nan) begin
      res = '0;
      inv = 1'b1;
    end else if (p_signed) begin
      inv = s_ovf;
      res = s_ovf ? (p_neg ? ~pos_lim : pos_lim) : twos;
    end else begin
      inv = u_neg | u_ovf;
      res = u_neg ? 64'd0 : (u_ovf ? ulim : rmag[63:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done    <= 1'b0;
      out_val     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_done    <= p_vld;
      out_invalid <= p_vld & inv;
      out_inexact <= p_vld & (p_g | p_st) & ~inv;
      if (p_vld) out_val <= res;
    end
  end
endmodule

// File: rtl/flt_to_fixed_chk.sv
`timescale 1ns/1ps
module flt_to_fixed_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [31:0] in_op,
  input logic        in_signed,
  input logic [1:0]  in_width,
  input logic        out_done,
  input logic [63:0] out_val,
  input logic        out_invalid,
  input logic        out_inexact
);
  p_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##2 out_done);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> ##2 !out_done);
  p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> !(out_invalid && out_inexact));
  p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> (!out_invalid && !out_inexact));
  p_nan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (&in_op[30:23]) && (|in_op[22:0])) |-> ##2 (out_invalid && out_val == 64'd0));
  p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op[30:23] == 8'd0) |-> ##2 (out_val == 64'd0 && !out_invalid && !out_inexact));
  p_uneg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_signed && in_op[31]) |-> ##2 (out_val == 64'd0));
  p_sext16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_signed && in_width == 2'd0) |-> ##2 (out_val[63:15] == '0 || (&out_val[63:15])));
endmodule

bind flt_to_fixed flt_to_fixed_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_signed(in_signed),
  .in_width(in_width), .out_done(out_done), .out_val(out_val),
  .out_invalid(out_invalid), .out_inexact(out_inexact)
);

// File: tb/tb_flt_to_fixed.sv
`timescale 1ns/1ps
module tb_flt_to_fixed;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] in_op = '0;
  logic        in_signed = 1'b0;
  logic [1:0]  in_width = '0;
  logic [6:0]  in_fbits = '0;
  logic [1:0]  in_rmode = '0;
  logic        out_done;
  logic [63:0] out_val;
  logic        out_invalid;
  logic        out_inexact;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  bit          qv[$];
  logic [63:0] qval[$];
  bit          qinv[$];
  bit          qinx[$];
  string       qtag[$];

  always #2 clk = ~clk;

  flt_to_fixed dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op), .in_signed(in_signed),
    .in_width(in_width), .in_fbits(in_fbits), .in_rmode(in_rmode),
    .out_done(out_done), .out_val(out_val), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] op, input bit sg, input logic [1:0] ws,
                                input logic [6:0] fb, input logic [1:0] rm,
                                output logic [63:0] val, output bit inv, output bit inx);
    int w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 32 : 64;
    bit s = op[31];
    int e = int'(op[30:23]);
    logic [511:0] x;
    logic [311:0] ip, r, lim;
    logic [199:0] fr;
    bit up;
    val = '0; inv = 1'b0; inx = 1'b0;
    if (e == 0) return;
    if (e == 255 && op[22:0] != 0) begin inv = 1'b1; return; end
    if (e == 255) begin
      r = 312'd1 << 300;
    end else begin
      x = 512'({1'b1, op[22:0]}) << (200 + e - 150 + int'(fb));
      ip = x[511:200];
      fr = x[199:0];
      inx = (fr != 0);
      case (rm)
        2'd0: up = fr[199] && ((fr[198:0] != 0) || ip[0]);
        2'd1: up = !s && inx;
        2'd2: up = s && inx;
        default: up = 1'b0;
      endcase
      r = ip + 312'(up);
    end
    lim = (312'd1 << (w - 1)) - 312'd1;
    if (sg) begin
      if (!s && r > lim) begin inv = 1'b1; val = (64'd1 << (w - 1)) - 64'd1; end
      else if (s && r > lim + 312'd1) begin inv = 1'b1; val = -(64'd1 << (w - 1)); end
      else val = s ? -r[63:0] : r[63:0];
    end else begin
      if (s && r != 0) begin inv = 1'b1; val = '0; end
      else if (!s && r > ((312'd1 << w) - 312'd1)) begin
        inv = 1'b1; val = (w == 64) ? {64{1'b1}} : (64'd1 << w) - 64'd1;
      end
      else val = s ? 64'd0 : r[63:0];
    end
    if (inv) inx = 1'b0;
  endfunction

  task automatic step(input bit v, input logic [31:0] op, input bit sg, input logic [1:0] ws,
                      input logic [6:0] fb, input logic [1:0] rm, input string tag);
    logic [63:0] ev;
    bit einv, einx;
    if (qv.size() == 2) begin
      bit pv = qv.pop_front();
      logic [63:0] pval = qval.pop_front();
      bit pinv = qinv.pop_front();
      bit pinx = qinx.pop_front();
      string ptag = qtag.pop_front();
      chk(out_done == pv, "R1", "done", 64'(out_done), 64'(pv));
      if (pv) begin
        chk(out_val == pval, ptag, "value", out_val, pval);
        chk(out_invalid == pinv, ptag, "invalid", 64'(out_invalid), 64'(pinv));
        chk(out_inexact == pinx, pinv ? "R9" : ptag, "inexact", 64'(out_inexact), 64'(pinx));
      end else begin
        chk(!out_invalid && !out_inexact, "R12", "idle flags",
            64'({out_invalid, out_inexact}), 64'd0);
      end
    end
    in_vld = v; in_op = op; in_signed = sg; in_width = ws; in_fbits = fb; in_rmode = rm;
    model(op, sg, ws, fb, rm, ev, einv, einx);
    qv.push_back(v); qval.push_back(ev); qinv.push_back(einv); qinx.push_back(einx);
    qtag.push_back(tag);
    @(negedge clk);
  endtask

  task automatic cv(input logic [31:0] op, input bit sg, input logic [1:0] ws,
                    input logic [6:0] fb, input logic [1:0] rm, input string tag);
    step(1'b1, op, sg, ws, fb, rm, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_done == 1'b0 && out_val == 64'd0 && !out_invalid && !out_inexact, "R12", "reset state",
        out_val, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    cv(32'h3FC00000, 1, 2'd1, 0, 2'd0, "R3");
    cv(32'h40200000, 1, 2'd1, 0, 2'd0, "R3");
    cv(32'hC0200000, 1, 2'd1, 0, 2'd0, "R3");
    cv(32'hC0200000, 1, 2'd1, 0, 2'd1, "R3");
    cv(32'hC0200000, 1, 2'd1, 0, 2'd2, "R3");
    cv(32'hC0200000, 1, 2'd1, 0, 2'd3, "R3");
    cv(32'h40200000, 1, 2'd1, 0, 2'd1, "R3");
    cv(32'h3F400000, 1, 2'd0, 1, 2'd0, "R2");
    cv(32'h3F800000, 1, 2'd1, 4, 2'd0, "R2");
    cv(32'h3F800000, 0, 2'd2, 63, 2'd0, "R2");
    cv(32'h3F800000, 1, 2'd2, 64, 2'd0, "R7");
    cv(32'h3F800000, 0, 2'd2, 127, 2'd0, "R8");
    cv(32'h00000000, 1, 2'd0, 0, 2'd0, "R5");
    cv(32'h80000000, 0, 2'd1, 9, 2'd1, "R5");
    cv(32'h00000001, 1, 2'd2, 127, 2'd1, "R5");
    cv(32'h807FFFFF, 1, 2'd2, 100, 2'd2, "R5");
    cv(32'h7FC00001, 1, 2'd1, 0, 2'd0, "R6");
    cv(32'hFF800001, 0, 2'd2, 5, 2'd3, "R6");
    cv(32'h7F800000, 1, 2'd0, 0, 2'd0, "R11");
    cv(32'hFF800000, 1, 2'd0, 0, 2'd0, "R11");
    cv(32'hFF800000, 0, 2'd1, 0, 2'd0, "R11");
    cv(32'h7F800000, 0, 2'd2, 0, 2'd0, "R11");
    cv(32'h471C4000, 1, 2'd0, 0, 2'd0, "R7");
    cv(32'hC7000000, 1, 2'd0, 0, 2'd0, "R7");
    cv(32'hC7000100, 1, 2'd0, 0, 2'd0, "R7");
    cv(32'h46FFFE00, 1, 2'd0, 0, 2'd0, "R7");
    cv(32'h47000000, 1, 2'd0, 0, 2'd0, "R7");
    cv(32'h5F000000, 1, 2'd2, 0, 2'd0, "R7");
    cv(32'hDF000000, 1, 2'd3, 0, 2'd0, "R10");
    cv(32'h5F000000, 0, 2'd3, 0, 2'd0, "R10");
    cv(32'hBE800000, 0, 2'd1, 0, 2'd3, "R8");
    cv(32'hBF400000, 0, 2'd1, 0, 2'd0, "R8");
    cv(32'h477FFF00, 0, 2'd0, 0, 2'd0, "R8");
    cv(32'h47800000, 0, 2'd0, 0, 2'd0, "R8");
    cv(32'h4F800000, 0, 2'd1, 0, 2'd0, "R8");
    cv(32'hC2F70000, 1, 2'd0, 2, 2'd0, "R10");
    cv(32'hC2F70000, 1, 2'd1, 2, 2'd0, "R10");
    cv(32'h42F70000, 0, 2'd0, 2, 2'd0, "R10");
    cv(32'h3EAAAAAB, 1, 2'd1, 8, 2'd0, "R4");
    cv(32'h3EAAAAAB, 1, 2'd1, 8, 2'd1, "R4");
    step(1'b0, 32'h0, 0, 2'd0, 0, 2'd0, "R1");
    cv(32'h3F800000, 1, 2'd1, 0, 2'd0, "R1");
    step(1'b0, 32'h0, 0, 2'd0, 0, 2'd0, "R1");
    step(1'b0, 32'h0, 0, 2'd0, 0, 2'd0, "R1");

    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom_range(0, 5) != 0);
      logic [7:0] e = (i % 4 == 0) ? 8'($urandom) : 8'($urandom_range(100, 190));
      logic [31:0] op = {1'($urandom), e, 23'($urandom)};
      logic [6:0] fb = (i % 5 == 0) ? 7'($urandom) : 7'($urandom_range(0, 40));
      step(v, op, 1'($urandom), 2'($urandom), fb, 2'($urandom), "R2");
    end
    step(1'b0, 32'h0, 0, 2'd0, 0, 2'd0, "R1");
    step(1'b0, 32'h0, 0, 2'd0, 0, 2'd0, "R1");
    step(1'b0, 32'h0, 0, 2'd0, 0, 2'd0, "R1");

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected 0 remaining cycles", 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule